// File: doc/BRIEF.md
# Synchronous SRAM cycle decoder

This block sits behind the control pins of a pipelined synchronous SRAM whose data pins are shared between read and write traffic. At every rising clock edge that is not a wait state it classifies the sampled controls as one of four operations: idle (deselect), read, write, or write abort. A read with the output enable inactive is a dummy read: it is decoded as a read, but nothing reaches the bus. The classification follows each operation down a fixed-length pipeline to its data phase. There the block drives per-byte write strobes to the storage array, or it enables the data-bus drivers for a read.

A low advance/load pin starts a new burst, and the external address is loaded through a pulse to the separate burst address sequencer. A high advance/load pin continues the burst kind that was last started and asks the sequencer to step. The output-enable pin is not registered. It is combined with the data-phase operation, so the bus drivers follow it within the same clock period, but never during a write or a write abort.

Top module: `sram_cycle_dec`

## Requirements
- R1: When `cen_n` is low, `adv_ld` is low and any bit of `cs_n` is high, `cyc_op` is 0 (idle) and `burst_load` stays low. That cycle's data phase, two advancing edges later, shows `phase_op` 0 with `dq_oe` low.
- R2: When `cen_n` is low and `adv_ld` is high, `cs_n` and `we_n` are ignored. `cyc_op` repeats the last started burst kind (1 read, 2 write) and `burst_step` is high. If the last begin cycle was an idle or an abort, `cyc_op` is 0 and `burst_step` stays low.
- R3: When `cen_n`, `adv_ld` and every bit of `cs_n` are low and `we_n` is high, `cyc_op` is 1 and `burst_load` is high. In that cycle's data phase, `dq_oe` is high only if `oe_n` is low; with `oe_n` high it is a dummy read and `dq_oe` stays low.
- R4: With the same begin conditions but `we_n` low, at least one low bit of `bs_n` gives `cyc_op` 2 with `burst_load` high. With all `bs_n` bits high, `cyc_op` is 3 (abort) and `burst_load` stays low. The abort's data phase has `arr_be` all zero, and a following continue cycle acts as idle.
- R5: While `phase_op` is 2 (write), `dq_oe` is low whatever `oe_n` is.
- R6: During a read data phase, `dq_oe` follows the inverse of `oe_n` with no clock edge needed.
- R7: While `cen_n` is high, `cyc_op` is 0, `burst_load`, `burst_step` and `arr_be` are low, and `phase_op` and the stored burst kind hold.
- R8: While `rst_n` is low, and right after it is released, `phase_op` is 0, `arr_be` is zero and `dq_oe` is low even with `oe_n` low.
- R9: In a write data phase with `cen_n` low, `arr_be[i]` is high exactly when `bs_n[i]` was low in the address cycle. Bit i refers to byte i, and the selects are sampled again in every cycle of a burst.
- R10: `phase_op` equals the `cyc_op` sampled two advancing clock edges earlier, so begin cycles that alternate read and write back to back need no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; controls are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | CS_W | Chip selects, all low to select |
| adv_ld | input | 1 | Low starts a burst, high continues it |
| we_n | input | 1 | Active-low write enable for begin cycles |
| bs_n | input | BYTES | Active-low byte selects, bit i for byte i |
| oe_n | input | 1 | Asynchronous active-low output enable |
| cen_n | input | 1 | Active-low clock enable, high for a wait state |
| cyc_op | output | 2 | Operation decoded this cycle: 0 idle, 1 read, 2 write, 3 abort |
| burst_load | output | 1 | Sequencer loads the external address |
| burst_step | output | 1 | Sequencer moves to the next burst address |
| phase_op | output | 2 | Operation now in its data phase, same coding |
| arr_be | output | BYTES | Active-high byte write strobes to the array |
| dq_oe | output | 1 | Data bus driver enable |

## Verification
The assertions assume every control input is settled one full period before the rising edge it is sampled on, and that reset is applied at least once before the first operation. The only exception is `oe_n`, which may change at any time but is not covered by any clocked property. The bench changes all controls at falling edges, stays clear of rising edges, and toggles `oe_n` several times inside a single wait-state period. The burst-kind assumption (a continue cycle follows only a begin cycle or another continue) is not required. Continue cycles after an idle or an abort are applied on purpose, to show that they decode as idle.

// File: rtl/sram_dec_pkg.sv
package sram_dec_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2,
    OP_ABT  = 2'd3
  } op_e;

  // Classify one sampled control set; adv selects the continue path.
  function automatic op_e next_op(input logic adv, input logic sel_ok,
                                  input logic we_n, input logic any_byte,
                                  input op_e kind);
    if (adv) begin
      if (kind == OP_RD) return OP_RD;
      if (kind == OP_WR) return OP_WR;
      return OP_IDLE;
    end
    if (!sel_ok) return OP_IDLE;
    if (we_n) return OP_RD;
    if (any_byte) return OP_WR;
    return OP_ABT;
  endfunction

  // Burst kind remembered for continue cycles; aborts start nothing.
  function automatic op_e kind_of(input op_e op);
    if (op == OP_RD) return OP_RD;
    if (op == OP_WR) return OP_WR;
    return OP_IDLE;
  endfunction

endpackage

// File: rtl/cyc_decode.sv
module cyc_decode
  import sram_dec_pkg::*;
#(
  parameter int CS_W  = 3,
  parameter int BYTES = 2
) (
  input  logic [CS_W-1:0]  cs_n,
  input  logic             adv_ld,
  input  logic             we_n,
  input  logic [BYTES-1:0] bs_n,
  input  logic             cen_n,
  input  op_e              kind,
  output op_e              op,
  output logic             load,
  output logic             step,
  output logic [BYTES-1:0] be
);

  logic sel_ok;
  logic any_byte;

  assign sel_ok   = ~|cs_n;
  assign any_byte = ~&bs_n;

  always_comb begin
    if (cen_n) op = OP_IDLE;
    else       op = next_op(adv_ld, sel_ok, we_n, any_byte, kind);
  end

  assign load = !cen_n && !adv_ld && (op == OP_RD || op == OP_WR);
  assign step = !cen_n && adv_ld && (kind != OP_IDLE);
  assign be   = (op == OP_WR) ? ~bs_n : '0;

endmodule

// File: rtl/cyc_pipe.sv
module cyc_pipe
  import sram_dec_pkg::*;
#(
  parameter int BYTES = 2,
  parameter int LAT   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             adv_ld,
  input  op_e              in_op,
  input  logic [BYTES-1:0] in_be,
  output op_e              kind,
  output op_e              ph_op,
  output logic [BYTES-1:0] ph_be
);

  localparam int LAST = LAT - 1;

  op_e              st_op [LAT];
  logic [BYTES-1:0] st_be [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin
        st_op[i] <= OP_IDLE;
        st_be[i] <= '0;
      end
    end else if (adv) begin
      st_op[0] <= in_op;
      st_be[0] <= in_be;
      for (int i = 1; i < LAT; i++) begin
        st_op[i] <= st_op[i-1];
        st_be[i] <= st_be[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                kind <= OP_IDLE;
    else if (adv && !adv_ld)   kind <= kind_of(in_op);
  end

  assign ph_op = st_op[LAST];
  assign ph_be = st_be[LAST];

  // R7: a wait state freezes the data phase and the burst kind
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(ph_op) && $stable(kind)));

  generate
    if (LAT >= 2) begin : g_lat_chk
      // R10: the data phase receives the stage ahead of it on each advance
      assert_phase_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (ph_op == $past(st_op[LAT-2])));
    end
  endgenerate

endmodule

// File: rtl/bus_gate.sv
module bus_gate
  import sram_dec_pkg::*;
#(
  parameter int BYTES = 2
) (
  input  op_e              ph_op,
  input  logic [BYTES-1:0] ph_be,
  input  logic             oe_n,
  input  logic             cen_n,
  output logic             dq_oe,
  output logic [BYTES-1:0] arr_be
);

  logic ph_is_rd;
  logic ph_is_wr;

  assign ph_is_rd = (ph_op == OP_RD);
  assign ph_is_wr = (ph_op == OP_WR);

  assign dq_oe  = ph_is_rd && !oe_n;
  assign arr_be = (ph_is_wr && !cen_n) ? ph_be : '0;

endmodule

// File: rtl/sram_cycle_dec.sv
module sram_cycle_dec
  import sram_dec_pkg::*;
#(
  parameter int CS_W  = 3,
  parameter int BYTES = 2,
  parameter int LAT   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CS_W-1:0]  cs_n,
  input  logic             adv_ld,
  input  logic             we_n,
  input  logic [BYTES-1:0] bs_n,
  input  logic             oe_n,
  input  logic             cen_n,
  output logic [1:0]       cyc_op,
  output logic             burst_load,
  output logic             burst_step,
  output logic [1:0]       phase_op,
  output logic [BYTES-1:0] arr_be,
  output logic             dq_oe
);

  op_e              dec_op;
  op_e              burst_kind;
  op_e              ph_op;
  logic [BYTES-1:0] dec_be;
  logic [BYTES-1:0] ph_be;
  logic             advance;

  assign advance = !cen_n;

  cyc_decode #(.CS_W(CS_W), .BYTES(BYTES)) u_decode (
    .cs_n   (cs_n),
    .adv_ld (adv_ld),
    .we_n   (we_n),
    .bs_n   (bs_n),
    .cen_n  (cen_n),
    .kind   (burst_kind),
    .op     (dec_op),
    .load   (burst_load),
    .step   (burst_step),
    .be     (dec_be)
  );

  cyc_pipe #(.BYTES(BYTES), .LAT(LAT)) u_pipe (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (advance),
    .adv_ld (adv_ld),
    .in_op  (dec_op),
    .in_be  (dec_be),
    .kind   (burst_kind),
    .ph_op  (ph_op),
    .ph_be  (ph_be)
  );

  bus_gate #(.BYTES(BYTES)) u_gate (
    .ph_op  (ph_op),
    .ph_be  (ph_be),
    .oe_n   (oe_n),
    .cen_n  (cen_n),
    .dq_oe  (dq_oe),
    .arr_be (arr_be)
  );

  assign cyc_op   = dec_op;
  assign phase_op = ph_op;

  // R1: a begin cycle without every select active loads nothing
  assert_desel_no_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld && (|cs_n)) |-> (!burst_load && cyc_op == 2'd0));

  // R2: continuing after an idle or abort stays idle
  assert_idle_continue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv_ld && burst_kind == OP_IDLE) |-> (cyc_op == 2'd0 && !burst_step));

  // R2: load and step never pulse together
  assert_load_step_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(burst_load && burst_step));

  // R4: an aborted write reaches its data phase without strobes
  assert_abort_no_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_op == 2'd3) |-> (arr_be == '0));

  // R5: the bus is never driven during a write data phase
  assert_write_tristate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_op == 2'd2) |-> !dq_oe);

  // R7: a wait state fires no strobes and no sequencer pulses
  assert_wait_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |-> (arr_be == '0 && !burst_load && !burst_step));

endmodule

// File: tb/test_sram_cycle_dec.sv
module test_sram_cycle_dec;

  localparam int NV = 17;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [2:0] cs_n = 3'b111;
  logic       adv_ld = 1'b0;
  logic       we_n = 1'b1;
  logic [1:0] bs_n = 2'b11;
  logic       oe_n = 1'b0;
  logic       cen_n = 1'b0;
  logic [1:0] cyc_op;
  logic       burst_load;
  logic       burst_step;
  logic [1:0] phase_op;
  logic [1:0] arr_be;
  logic       dq_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sram_cycle_dec i_sram_cycle_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .adv_ld     (adv_ld),
    .we_n       (we_n),
    .bs_n       (bs_n),
    .oe_n       (oe_n),
    .cen_n      (cen_n),
    .cyc_op     (cyc_op),
    .burst_load (burst_load),
    .burst_step (burst_step),
    .phase_op   (phase_op),
    .arr_be     (arr_be),
    .dq_oe      (dq_oe)
  );

  // cs_n adv we_n bs_n oe_n cen_n | cyc load step phase be oe
  localparam logic [17:0] VEC [NV] = '{
    18'b000_0_1_11_0_0_01_1_0_00_00_0, // v0  read begin
    18'b000_0_0_10_0_0_10_1_0_00_00_0, // v1  write byte0
    18'b000_0_1_11_0_0_01_1_0_01_00_1, // v2  read, v0 on bus
    18'b111_1_0_11_0_0_01_0_1_10_01_0, // v3  continue read, v1 writes byte0
    18'b000_0_0_00_1_0_10_1_0_01_00_0, // v4  write both, dummy read phase
    18'b111_1_1_01_0_0_10_0_1_01_00_1, // v5  continue write byte1
    18'b000_0_1_11_0_1_00_0_0_10_00_0, // v6  wait state
    18'b011_0_1_11_0_0_00_0_0_10_11_0, // v7  deselect, v4 strobes
    18'b000_1_1_11_0_0_00_0_0_10_10_0, // v8  continue after deselect
    18'b000_0_0_11_0_0_11_0_0_00_00_0, // v9  abort
    18'b000_1_0_00_0_0_00_0_0_00_00_0, // v10 continue after abort
    18'b000_0_1_11_0_0_01_1_0_11_00_0, // v11 read
    18'b000_0_0_01_0_0_10_1_0_00_00_0, // v12 write byte1
    18'b000_0_1_11_0_0_01_1_0_01_00_1, // v13 read
    18'b101_0_1_11_0_0_00_0_0_10_10_0, // v14 deselect, v12 write phase
    18'b111_0_1_11_0_0_00_0_0_01_00_1, // v15 deselect, v13 read phase
    18'b111_0_1_11_0_0_00_0_0_00_00_0  // v16 deselect
  };

  string tags [NV] = '{"R3", "R9", "R3", "R9", "R3", "R2", "R7", "R7", "R2",
                       "R4", "R4", "R10", "R10", "R10", "R5", "R1", "R1"};

  task automatic chk(input string req, input string what,
                     input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(20 * 10000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    #6;
    // R8: reset state with oe_n low
    chk("R8", "phase_op in reset", {2'b0, phase_op}, 4'd0);
    chk("R8", "arr_be in reset", {2'b0, arr_be}, 4'd0);
    chk("R8", "dq_oe in reset", {3'b0, dq_oe}, 4'd0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R8", "dq_oe after release", {3'b0, dq_oe}, 4'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cs_n   = VEC[i][17:15];
      adv_ld = VEC[i][14];
      we_n   = VEC[i][13];
      bs_n   = VEC[i][12:11];
      oe_n   = VEC[i][10];
      cen_n  = VEC[i][9];
      #2;
      chk(tags[i], "cyc_op", {2'b0, cyc_op}, {2'b0, VEC[i][8:7]});
      chk(tags[i], "burst_load", {3'b0, burst_load}, {3'b0, VEC[i][6]});
      chk(tags[i], "burst_step", {3'b0, burst_step}, {3'b0, VEC[i][5]});
      chk(tags[i], "phase_op", {2'b0, phase_op}, {2'b0, VEC[i][4:3]});
      chk(tags[i], "arr_be", {2'b0, arr_be}, {2'b0, VEC[i][2:1]});
      chk(tags[i], "dq_oe", {3'b0, dq_oe}, {3'b0, VEC[i][0]});
    end

    // R6: bring a read into its data phase, then freeze and toggle oe_n
    @(negedge clk);
    cs_n = 3'b000; adv_ld = 1'b0; we_n = 1'b1; bs_n = 2'b11; oe_n = 1'b1; cen_n = 1'b0;
    @(negedge clk);
    cs_n = 3'b111;
    @(negedge clk);
    cen_n = 1'b1;
    oe_n  = 1'b0;
    #2 chk("R6", "dq_oe oe_n low", {3'b0, dq_oe}, 4'd1);
    oe_n = 1'b1;
    #2 chk("R6", "dq_oe oe_n high", {3'b0, dq_oe}, 4'd0);
    oe_n = 1'b0;
    #2 chk("R6", "dq_oe oe_n low again", {3'b0, dq_oe}, 4'd1);
    chk("R7", "phase held in wait", {2'b0, phase_op}, 4'd1);

    // R8: reset in the middle of a read data phase
    rst_n = 1'b0;
    #1;
    chk("R8", "dq_oe mid reset", {3'b0, dq_oe}, 4'd0);
    chk("R8", "phase_op mid reset", {2'b0, phase_op}, 4'd0);
    @(negedge clk);
    rst_n = 1'b1;
    cen_n = 1'b0;
    // R2: after reset the burst kind is idle, so a continue is idle
    adv_ld = 1'b1;
    cs_n   = 3'b000;
    #2;
    chk("R2", "continue after reset", {2'b0, cyc_op}, 4'd0);
    chk("R2", "no step after reset", {3'b0, burst_step}, 4'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule